// File: doc/BRIEF.md
# Burst-Tracking Memory Slave

This block is a single-port memory slave for an AHB-Lite-style pipelined bus. It serves zero-wait reads and writes of bytes, halfwords and words to a small on-chip memory. Alongside the datapath it follows every burst in flight. For each burst it keeps the control captured on the first beat, the number of beats done so far and the address the next sequential beat must carry. Incrementing and wrapping bursts of fixed length are supported, as well as the open-ended incrementing burst and single transfers.

A burst may stop before its beat count in two ways. The first is the slave's own error response, which it gives for an address beyond the memory. The second is the bus moving to a new transfer, either a fresh first beat or an idle slot. Both are legal: the tracker drops the old burst and serves whatever comes next. A sequential beat that does not continue the tracked burst raises a one-cycle violation flag. Such a beat has the wrong address, changed control, or no burst open for it. The beat is still served as addressed, since the bus gives no defined way to refuse it.

Top module: `burst_track_slave`

## Requirements
- R1: While and directly after reset, readyOut is 1, respOut is 0 (OKAY) and violation is 0.
- R2: An in-range transfer gets a zero-wait OKAY response. A word written in one transfer is returned on rdataOut in the data phase of a later read of that word.
- R3: sizeIn encodes 0 = byte, 1 = halfword, 2 = word. A byte write at byte offset k changes only bits 8k+7..8k of the word. A halfword write at offset 2 changes only bits 31..16.
- R4: transIn encodes 0 = idle, 1 = busy, 2 = first beat (NONSEQ), 3 = sequential beat (SEQ). burstIn encodes 0 single, 1 open incrementing, 3/5/7 incrementing 4/8/16, 2/4/6 wrapping 4/8/16. In an incrementing burst each SEQ beat at the previous address plus 2^size, with unchanged control, gives no violation. An example is an 8-beat word write from 0x30 through 0x4C.
- R5: In a wrapping burst the next address wraps within an aligned block of beats × 2^size bytes. A 4-beat word wrap from 0x38 runs 0x3C, 0x30, 0x34 with no violation.
- R6: A SEQ beat is flagged if its address differs from the expected one, or if any of write, size, burst, protection or lock differs from the first beat. For such a beat, violation is 1 in the cycle after its address phase, and the transfer is still served.
- R7: A NONSEQ arriving before a burst's beat count is reached ends that burst without a violation. Its own control becomes the new reference, and it is served with OKAY.
- R8: A burst ends when it reaches its beat count or when an idle slot (or a deselected cycle) is accepted. A SEQ beat after that raises violation.
- R9: An address at or above MEM_WORDS×4 gets a two-cycle ERROR: first readyOut=0 with respOut=1, then readyOut=1 with respOut=1. Its write is dropped and its burst ends. A NONSEQ in the second cycle is accepted without violation.
- R10: A busy transfer inside a burst gets a zero-wait OKAY and advances neither the expected address nor the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selIn | input | 1 | Slave select |
| addrIn | input | ADDR_W | Byte address, address phase |
| transIn | input | 2 | Transfer type |
| writeIn | input | 1 | 1 = write |
| sizeIn | input | 3 | Transfer size, log2 bytes |
| burstIn | input | 3 | Burst kind |
| protIn | input | 4 | Protection attributes |
| lockIn | input | 1 | Locked sequence |
| wdataIn | input | DATA_W | Write data, data phase |
| readyIn | input | 1 | Bus-wide ready (previous transfer complete) |
| readyOut | output | 1 | This slave's ready |
| respOut | output | 1 | 0 = OKAY, 1 = ERROR |
| rdataOut | output | DATA_W | Read data, data phase |
| violation | output | 1 | Sequential beat broke the tracked burst |

## Verification
Every result belongs to the data phase, which is one clock after the address phase that causes it. This covers rdataOut, the violation pulse and the first error cycle. The second error cycle comes one clock later again. The bench drives each address phase just after a rising edge, together with the write data of the previous transfer. It then samples at the falling edge of that same cycle, so each vector's outcomes are judged exactly one cycle after that vector was presented. The error sequence is stepped by hand, one check per cycle of the stall and its release.

// File: rtl/burst_track_pkg.sv
package burst_track_pkg;

  localparam logic [1:0] TR_IDLE   = 2'd0;
  localparam logic [1:0] TR_BUSY   = 2'd1;
  localparam logic [1:0] TR_NONSEQ = 2'd2;
  localparam logic [1:0] TR_SEQ    = 2'd3;

  typedef enum logic [1:0] {ERR_NONE, ERR_STALL, ERR_DONE} errState_e;

  // control that must hold steady across the beats of one burst
  typedef struct packed {
    logic       write;
    logic [2:0] size;
    logic [2:0] burst;
    logic [3:0] prot;
    logic       lock;
  } busCtl_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic isWrite;
  } dpStrobe_t;

  // beats per burst kind; 0 means open-ended
  function automatic logic [4:0] burstBeats(input logic [2:0] kind);
    case (kind)
      3'd0:       burstBeats = 5'd1;
      3'd1:       burstBeats = 5'd0;
      3'd2, 3'd3: burstBeats = 5'd4;
      3'd4, 3'd5: burstBeats = 5'd8;
      default:    burstBeats = 5'd16;
    endcase
  endfunction

  function automatic logic isWrapBurst(input logic [2:0] kind);
    isWrapBurst = (kind == 3'd2) || (kind == 3'd4) || (kind == 3'd6);
  endfunction

endpackage

// File: rtl/burst_track_ctrl.sv
module burst_track_ctrl
  import burst_track_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MEM_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [1:0]        transIn,
  input  busCtl_t           ctlIn,
  input  logic              readyIn,
  output logic              readyOut,
  output logic              respOut,
  output logic              violation,
  output dpStrobe_t         strobe
);

  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(MEM_BYTES);

  logic accept, inRange, isSeq, isNonseq, idleSlot, busySlot;
  assign accept   = selIn && readyIn && transIn[1];
  assign isSeq    = transIn == TR_SEQ;
  assign isNonseq = transIn == TR_NONSEQ;
  assign inRange  = addrIn < LIMIT;
  assign idleSlot = readyIn && (!selIn || transIn == TR_IDLE);
  assign busySlot = selIn && readyIn && transIn == TR_BUSY;

  // two-cycle error response
  errState_e errState, errNext;
  always_comb begin
    if (errState == ERR_STALL)    errNext = ERR_DONE;
    else if (accept && !inRange)  errNext = ERR_STALL;
    else                          errNext = ERR_NONE;
  end
  assign readyOut = errState != ERR_STALL;
  assign respOut  = errState != ERR_NONE;

  // address the following beat must carry
  logic [4:0]        beats;
  logic [ADDR_W-1:0] stepAddr, wrapMask, seqNext;
  always_comb begin
    beats    = burstBeats(ctlIn.burst);
    stepAddr = addrIn + (ADDR_W'(1) << ctlIn.size);
    wrapMask = (ADDR_W'(beats) << ctlIn.size) - ADDR_W'(1);
    if (isWrapBurst(ctlIn.burst)) seqNext = (addrIn & ~wrapMask) | (stepAddr & wrapMask);
    else                          seqNext = stepAddr;
  end

  // burst tracker state
  logic              active;
  logic [4:0]        beatCnt;
  logic [ADDR_W-1:0] expAddr;
  busCtl_t           heldCtl;
  logic              seqBad, lastBeat;
  assign seqBad   = !active || (addrIn != expAddr) || (ctlIn != heldCtl);
  assign lastBeat = (beats != 5'd0) && (beatCnt + 5'd1 == beats);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errState  <= ERR_NONE;
      violation <= 1'b0;
      active    <= 1'b0;
      beatCnt   <= '0;
      expAddr   <= '0;
      heldCtl   <= '0;
    end else begin
      errState  <= errNext;
      violation <= accept && isSeq && seqBad;
      if (accept && isNonseq) begin
        heldCtl <= ctlIn;
        beatCnt <= 5'd1;
        expAddr <= seqNext;
        active  <= inRange && (beats != 5'd1);
      end else if (accept && isSeq) begin
        beatCnt <= beatCnt + 5'd1;
        expAddr <= seqNext;
        active  <= active && inRange && !lastBeat;
      end else if (idleSlot) begin
        active  <= 1'b0;
      end
    end
  end

  assign strobe.load    = accept && inRange;
  assign strobe.isWrite = ctlIn.write;

  AST_OOB_ERRORS: assert property (@(posedge clk) disable iff (!rstN)
    accept && !inRange |=> !readyOut && respOut); // R9
  AST_STALL_IS_ERROR: assert property (@(posedge clk) disable iff (!rstN)
    !readyOut |-> respOut); // R9
  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !readyOut |=> readyOut && respOut); // R9
  AST_ERROR_STARTS_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(respOut) |-> !readyOut); // R9
  AST_BUSY_ZERO_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    busySlot |=> readyOut && !respOut); // R10

endmodule

// File: rtl/burst_track_dp.sv
module burst_track_dp
  import burst_track_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 64,
  localparam int LANES    = DATA_W / 8,
  localparam int OFF_W    = $clog2(LANES),
  localparam int IDX_W    = $clog2(MEM_WORDS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic [IDX_W+OFF_W-1:0] addrIn,
  input  logic [2:0]             sizeIn,
  input  logic [DATA_W-1:0]      wdataIn,
  output logic [DATA_W-1:0]      rdataOut
);

  logic [DATA_W-1:0] mem [MEM_WORDS];
  logic [IDX_W-1:0]  phIdx;
  logic [LANES-1:0]  phLanes, laneMask;
  logic              phWrite;

  // a lane is written when it sits in the same aligned chunk as the offset
  always_comb begin
    for (int l = 0; l < LANES; l++)
      laneMask[l] = (OFF_W'(l) >> sizeIn) == (addrIn[OFF_W-1:0] >> sizeIn);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phIdx   <= '0;
      phLanes <= '0;
      phWrite <= 1'b0;
    end else if (strobe.load) begin
      phIdx   <= addrIn[OFF_W +: IDX_W];
      phLanes <= laneMask;
      phWrite <= strobe.isWrite;
    end else begin
      phWrite <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < MEM_WORDS; w++) mem[w] <= '0;
    end else if (phWrite) begin
      for (int l = 0; l < LANES; l++)
        if (phLanes[l]) mem[phIdx][8*l +: 8] <= wdataIn[8*l +: 8];
    end
  end

  assign rdataOut = mem[phIdx];

endmodule

// File: rtl/burst_track_slave.sv
module burst_track_slave
  import burst_track_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [1:0]        transIn,
  input  logic              writeIn,
  input  logic [2:0]        sizeIn,
  input  logic [2:0]        burstIn,
  input  logic [3:0]        protIn,
  input  logic              lockIn,
  input  logic [DATA_W-1:0] wdataIn,
  input  logic              readyIn,
  output logic              readyOut,
  output logic              respOut,
  output logic [DATA_W-1:0] rdataOut,
  output logic              violation
);

  localparam int LANES     = DATA_W / 8;
  localparam int OFF_W     = $clog2(LANES);
  localparam int IDX_W     = $clog2(MEM_WORDS);
  localparam int MEM_BYTES = MEM_WORDS * LANES;

  busCtl_t   ctl;
  dpStrobe_t strobe;
  assign ctl = '{write: writeIn, size: sizeIn, burst: burstIn, prot: protIn, lock: lockIn};

  burst_track_ctrl #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .selIn(selIn), .addrIn(addrIn), .transIn(transIn),
    .ctlIn(ctl), .readyIn(readyIn), .readyOut(readyOut), .respOut(respOut),
    .violation(violation), .strobe(strobe)
  );

  burst_track_dp #(.DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrIn(addrIn[IDX_W+OFF_W-1:0]),
    .sizeIn(sizeIn), .wdataIn(wdataIn), .rdataOut(rdataOut)
  );

endmodule

// File: tb/burst_track_slave_tb.sv
`timescale 1ns/1ps
module burst_track_slave_tb;

  localparam logic [1:0] IDL = 2'd0, BSY = 2'd1, NSQ = 2'd2, SQ = 2'd3;
  localparam logic [2:0] SGL = 3'd0, INC = 3'd1, W4 = 3'd2, I4 = 3'd3, I8 = 3'd5;

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  trans;
    logic [31:0] addr;
    logic        wr;
    logic [2:0]  size;
    logic [2:0]  burst;
    logic [31:0] wdata;
    logic        viol;
    logic        chk;
    logic [31:0] rd;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VEC [NV] = '{
    // R4: eight-beat incrementing word write from 0x30
    '{4'd4, NSQ, 32'h30, 1'b1, 3'd2, I8, 32'hA0000000, 1'b0, 1'b0, 32'h0},
    '{4'd4, SQ,  32'h34, 1'b1, 3'd2, I8, 32'hA0000001, 1'b0, 1'b0, 32'h0},
    '{4'd4, SQ,  32'h38, 1'b1, 3'd2, I8, 32'hA0000002, 1'b0, 1'b0, 32'h0},
    '{4'd4, SQ,  32'h3C, 1'b1, 3'd2, I8, 32'hA0000003, 1'b0, 1'b0, 32'h0},
    '{4'd4, SQ,  32'h40, 1'b1, 3'd2, I8, 32'hA0000004, 1'b0, 1'b0, 32'h0},
    '{4'd4, SQ,  32'h44, 1'b1, 3'd2, I8, 32'hA0000005, 1'b0, 1'b0, 32'h0},
    '{4'd4, SQ,  32'h48, 1'b1, 3'd2, I8, 32'hA0000006, 1'b0, 1'b0, 32'h0},
    '{4'd4, SQ,  32'h4C, 1'b1, 3'd2, I8, 32'hA0000007, 1'b0, 1'b0, 32'h0},
    // R5 and R2: four-beat wrapping read from 0x38
    '{4'd5, NSQ, 32'h38, 1'b0, 3'd2, W4, 32'h0, 1'b0, 1'b1, 32'hA0000002},
    '{4'd5, SQ,  32'h3C, 1'b0, 3'd2, W4, 32'h0, 1'b0, 1'b1, 32'hA0000003},
    '{4'd5, SQ,  32'h30, 1'b0, 3'd2, W4, 32'h0, 1'b0, 1'b1, 32'hA0000000},
    '{4'd5, SQ,  32'h34, 1'b0, 3'd2, W4, 32'h0, 1'b0, 1'b1, 32'hA0000001},
    // R6: wrong address on the third beat
    '{4'd6, NSQ, 32'h80, 1'b1, 3'd2, I4, 32'h11, 1'b0, 1'b0, 32'h0},
    '{4'd6, SQ,  32'h84, 1'b1, 3'd2, I4, 32'h22, 1'b0, 1'b0, 32'h0},
    '{4'd6, SQ,  32'h8C, 1'b1, 3'd2, I4, 32'h33, 1'b1, 1'b0, 32'h0},
    '{4'd8, IDL, 32'h0,  1'b0, 3'd2, SGL, 32'h0, 1'b0, 1'b0, 32'h0},
    // R7: new first beat cuts an incrementing burst short
    '{4'd7, NSQ, 32'hA0, 1'b1, 3'd2, I4, 32'h55, 1'b0, 1'b0, 32'h0},
    '{4'd7, SQ,  32'hA4, 1'b1, 3'd2, I4, 32'h66, 1'b0, 1'b0, 32'h0},
    '{4'd7, NSQ, 32'h30, 1'b0, 3'd2, SGL, 32'h0, 1'b0, 1'b1, 32'hA0000000},
    // R8: sequential beat after a single transfer
    '{4'd8, SQ,  32'h34, 1'b0, 3'd2, SGL, 32'h0, 1'b1, 1'b1, 32'hA0000001},
    // R6: write flag flips mid-burst
    '{4'd6, NSQ, 32'hC0, 1'b1, 3'd2, I4, 32'h77, 1'b0, 1'b0, 32'h0},
    '{4'd6, SQ,  32'hC4, 1'b0, 3'd2, I4, 32'h0, 1'b1, 1'b0, 32'h0},
    // R10: busy slot does not count as a beat
    '{4'd10, NSQ, 32'h40, 1'b0, 3'd2, I4, 32'h0, 1'b0, 1'b1, 32'hA0000004},
    '{4'd10, BSY, 32'h44, 1'b0, 3'd2, I4, 32'h0, 1'b0, 1'b0, 32'h0},
    '{4'd10, SQ,  32'h44, 1'b0, 3'd2, I4, 32'h0, 1'b0, 1'b1, 32'hA0000005},
    '{4'd10, SQ,  32'h48, 1'b0, 3'd2, I4, 32'h0, 1'b0, 1'b1, 32'hA0000006},
    '{4'd10, SQ,  32'h4C, 1'b0, 3'd2, I4, 32'h0, 1'b0, 1'b1, 32'hA0000007},
    '{4'd10, SQ,  32'h50, 1'b0, 3'd2, I4, 32'h0, 1'b1, 1'b0, 32'h0},
    // R8: idle slot ends an open-ended burst
    '{4'd8, NSQ, 32'h30, 1'b0, 3'd2, INC, 32'h0, 1'b0, 1'b1, 32'hA0000000},
    '{4'd8, SQ,  32'h34, 1'b0, 3'd2, INC, 32'h0, 1'b0, 1'b1, 32'hA0000001},
    '{4'd8, IDL, 32'h38, 1'b0, 3'd2, INC, 32'h0, 1'b0, 1'b0, 32'h0},
    '{4'd8, SQ,  32'h38, 1'b0, 3'd2, INC, 32'h0, 1'b1, 1'b1, 32'hA0000002},
    // R3: byte and halfword lanes
    '{4'd3, NSQ, 32'h41, 1'b1, 3'd0, SGL, 32'h00005500, 1'b0, 1'b0, 32'h0},
    '{4'd3, NSQ, 32'h4A, 1'b1, 3'd1, SGL, 32'hBEEF0000, 1'b0, 1'b0, 32'h0},
    '{4'd3, NSQ, 32'h40, 1'b0, 3'd2, SGL, 32'h0, 1'b0, 1'b1, 32'hA0005504},
    '{4'd3, NSQ, 32'h48, 1'b0, 3'd2, SGL, 32'h0, 1'b0, 1'b1, 32'hBEEF0006}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        selIn, writeIn, lockIn;
  logic [31:0] addrIn, wdataIn, rdataOut;
  logic [1:0]  transIn;
  logic [2:0]  sizeIn, burstIn;
  logic [3:0]  protIn;
  logic        readyIn, readyOut, respOut, violation;

  int nChecks = 0;
  int nErrors = 0;

  always #2.5 clk = ~clk;
  assign readyIn = readyOut;

  burst_track_slave u_dut (
    .clk(clk), .rstN(rstN), .selIn(selIn), .addrIn(addrIn), .transIn(transIn),
    .writeIn(writeIn), .sizeIn(sizeIn), .burstIn(burstIn), .protIn(protIn),
    .lockIn(lockIn), .wdataIn(wdataIn), .readyIn(readyIn), .readyOut(readyOut),
    .respOut(respOut), .rdataOut(rdataOut), .violation(violation)
  );

  task automatic check(input int req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] tr, input logic [31:0] ad, input logic wr,
                       input logic [2:0] sz, input logic [2:0] bu);
    selIn = 1'b1; transIn = tr; addrIn = ad; writeIn = wr;
    sizeIn = sz; burstIn = bu; protIn = 4'h3; lockIn = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    nErrors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    drive(IDL, 32'h0, 1'b0, 3'd2, SGL);
    wdataIn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(1, "ready in reset", 32'(readyOut), 32'd1);     // R1
    check(1, "resp in reset", 32'(respOut), 32'd0);       // R1
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    check(1, "violation after reset", 32'(violation), 32'd0); // R1
    check(1, "ready after reset", 32'(readyOut), 32'd1);      // R1

    // vector table: address phase i, data phase of i-1, checked at falling edge
    for (int i = 0; i <= NV; i++) begin
      vec_t cur, prv;
      cur = VEC[(i < NV) ? i : NV - 1];
      prv = VEC[(i > 0) ? i - 1 : 0];
      @(posedge clk); #1;
      if (i < NV) drive(cur.trans, cur.addr, cur.wr, cur.size, cur.burst);
      else        drive(IDL, 32'h0, 1'b0, 3'd2, SGL);
      wdataIn = (i > 0) ? prv.wdata : 32'h0;
      @(negedge clk);
      if (i > 0) begin
        check(int'(prv.req), $sformatf("vec %0d violation", i - 1), 32'(violation), 32'(prv.viol));
        check(2, $sformatf("vec %0d zero-wait okay", i - 1), {30'd0, readyOut, respOut}, 32'd2); // R2
        if (prv.chk)
          check(int'(prv.req), $sformatf("vec %0d rdata", i - 1), rdataOut, prv.rd);
      end
    end

    // R9: burst runs off the end of memory
    @(posedge clk); #1 drive(NSQ, 32'hF8, 1'b1, 3'd2, I4); wdataIn = 32'h0;
    @(posedge clk); #1 drive(SQ, 32'hFC, 1'b1, 3'd2, I4);  wdataIn = 32'h12345678;
    @(posedge clk); #1 drive(SQ, 32'h100, 1'b1, 3'd2, I4); wdataIn = 32'h9ABCDEF0;
    @(negedge clk);
    check(9, "in-range beat okay", {30'd0, readyOut, respOut}, 32'd2);
    @(posedge clk); #1 drive(SQ, 32'h104, 1'b1, 3'd2, I4); wdataIn = 32'hDEADBEEF;
    @(negedge clk);
    check(9, "error cycle 1 {ready,resp}", {30'd0, readyOut, respOut}, 32'd1);
    @(posedge clk); #1 drive(NSQ, 32'hF8, 1'b0, 3'd2, SGL); wdataIn = 32'h0;
    @(negedge clk);
    check(9, "error cycle 2 {ready,resp}", {30'd0, readyOut, respOut}, 32'd3);
    @(posedge clk); #1 drive(NSQ, 32'h0, 1'b0, 3'd2, SGL);
    @(negedge clk);
    check(9, "after error okay", {30'd0, readyOut, respOut}, 32'd2);
    check(9, "new control after error", 32'(violation), 32'd0);
    check(9, "read 0xF8", rdataOut, 32'h12345678);
    @(posedge clk); #1 drive(IDL, 32'h0, 1'b0, 3'd2, SGL);
    @(negedge clk);
    check(9, "dropped write did not alias", rdataOut, 32'h0);

    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule